// File: doc/BRIEF.md
# Link Timing-Condition Monitor

This block watches three free-running tick enables, one each for a writer, a bus that copies the writer's buffer, and a reader. All three are sampled on one clock. The link loses nothing, and duplicates nothing, when two ordering rules hold:

- every write is picked up by the bus before the writer overwrites its buffer;
- the reader samples each copied value before the bus copies the next new one.

The monitor reports each breach of these rules as it happens.

For every write, the monitor tracks the earliest bus tick strictly after it. This is the write's first fetch. Two checks follow from it:

- the write-gap check flags a second write that arrives while the previous write still has no fetch;
- the read-gap check flags a first fetch whose interval since the preceding first fetch held no read tick.

That interval is open at its start and closed at its end. Both error flags stay set until reset, and a saturating counter totals the breaches.

Top module: `link_order_monitor`

## Requirements
- R1: After reset (asynchronous, active low) both error flags and the violation count are zero.
- R2: A write tick that arrives while an earlier write has no fetch yet, with no bus tick in the same cycle, sets the write-gap flag in the following cycle.
- R3: A bus tick in the same cycle as a write tick fetches the earlier pending write, so that write pair is not a write-gap breach.
- R4: A bus tick in the same cycle as a write tick does not fetch that same write; a further write with no bus tick in between is a breach.
- R5: Two first fetches with no read tick anywhere in the interval between them set the read-gap flag in the cycle after the second one.
- R6: A read tick in the same cycle as a first fetch counts for the interval that this fetch closes.
- R7: A read tick in the same cycle as a first fetch does not count for the interval that this fetch opens.
- R8: Both error flags remain set until reset, whatever the later ticks are.
- R9: The violation count (CNT_W bits, 4 by default) rises by one per breach, one cycle after it, and holds at 2^CNT_W-1 once it reaches it.
- R10: Bus ticks with no write pending and read ticks are not fetch events, and on their own they raise no error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock for all tick enables |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_tick | input | 1 | Writer tick enable |
| bus_tick | input | 1 | Bus copy tick enable |
| rd_tick | input | 1 | Reader tick enable |
| wr_err | output | 1 | Sticky write-gap breach flag |
| rd_err | output | 1 | Sticky read-gap breach flag |
| viol_cnt | output | CNT_W | Saturating breach count |

## Verification
The assertions assume the three tick inputs are clean single-cycle samples that are known after reset. Ticks of any stream may coincide in any combination. The bench changes inputs only on the falling edge and holds each value for one full cycle, so every tick is seen exactly once. It places coincident ticks on purpose at the interval bounds that R3, R4, R6 and R7 describe.

// File: rtl/lom_pkg.sv
package lom_pkg;

  // A bus tick fetches a write only if that write was already pending.
  function automatic logic fetch_event(input logic bus_t, input logic pend);
    return bus_t & pend;
  endfunction

  // A new write while the old one is unfetched and no bus tick now.
  function automatic logic write_gap(input logic wr_t, input logic bus_t,
                                     input logic pend);
    return wr_t & pend & ~bus_t;
  endfunction

  // Closing fetch of an interval that saw no read, the bound read counting.
  function automatic logic read_gap(input logic ff, input logic opened,
                                    input logic rd_seen, input logic rd_t);
    return ff & opened & ~(rd_seen | rd_t);
  endfunction

endpackage

// File: rtl/lom_fetch_tracker.sv
module lom_fetch_tracker
  import lom_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic wr_tick,
  input  logic bus_tick,
  output logic wr_pend,
  output logic ff_evt,
  output logic gap_evt,
  output logic err
);

  assign ff_evt  = fetch_event(bus_tick, wr_pend);
  assign gap_evt = write_gap(wr_tick, bus_tick, wr_pend);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_pend <= 1'b0;
      err     <= 1'b0;
    end else begin
      wr_pend <= wr_tick | (wr_pend & ~bus_tick);
      err     <= err | gap_evt;
    end
  end

endmodule

// File: rtl/lom_read_window.sv
module lom_read_window
  import lom_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic ff_evt,
  input  logic rd_tick,
  output logic gap_evt,
  output logic err
);

  logic opened;   // at least one first fetch seen
  logic rd_seen;  // read tick strictly after the latest first fetch

  assign gap_evt = read_gap(ff_evt, opened, rd_seen, rd_tick);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      opened  <= 1'b0;
      rd_seen <= 1'b0;
      err     <= 1'b0;
    end else begin
      opened  <= opened | ff_evt;
      rd_seen <= ff_evt ? 1'b0 : (rd_seen | rd_tick);
      err     <= err | gap_evt;
    end
  end

endmodule

// File: rtl/lom_viol_counter.sv
module lom_viol_counter #(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             evt_a,
  input  logic             evt_b,
  output logic [CNT_W-1:0] cnt
);

  localparam logic [CNT_W:0] MAX_W = {1'b0, {CNT_W{1'b1}}};

  function automatic logic [CNT_W-1:0] sat_add(input logic [CNT_W-1:0] c,
                                               input logic [1:0] inc);
    logic [CNT_W:0] sum;
    sum = {1'b0, c} + {{(CNT_W-1){1'b0}}, inc};
    return (sum > MAX_W) ? MAX_W[CNT_W-1:0] : sum[CNT_W-1:0];
  endfunction

  logic [1:0] inc;
  assign inc = {1'b0, evt_a} + {1'b0, evt_b};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt <= '0;
    else        cnt <= sat_add(cnt, inc);
  end

endmodule

// File: rtl/link_order_monitor.sv
module link_order_monitor #(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_tick,
  input  logic             bus_tick,
  input  logic             rd_tick,
  output logic             wr_err,
  output logic             rd_err,
  output logic [CNT_W-1:0] viol_cnt
);

  logic wr_pend;
  logic ff_evt;
  logic wgap_evt;
  logic rgap_evt;

  lom_fetch_tracker u_fetch (
    .clk(clk), .rst_n(rst_n), .wr_tick(wr_tick), .bus_tick(bus_tick),
    .wr_pend(wr_pend), .ff_evt(ff_evt), .gap_evt(wgap_evt), .err(wr_err)
  );

  lom_read_window u_rwin (
    .clk(clk), .rst_n(rst_n), .ff_evt(ff_evt), .rd_tick(rd_tick),
    .gap_evt(rgap_evt), .err(rd_err)
  );

  lom_viol_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .evt_a(wgap_evt), .evt_b(rgap_evt),
    .cnt(viol_cnt)
  );

endmodule

// File: rtl/lom_checker.sv
module lom_checker #(
  parameter int CNT_W = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             wr_tick,
  input logic             bus_tick,
  input logic             wr_pend,
  input logic             ff_evt,
  input logic             wr_err,
  input logic             rd_err,
  input logic [CNT_W-1:0] viol_cnt
);

  localparam logic [CNT_W-1:0] CMAX = {CNT_W{1'b1}};

  p_reset_clear_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (!wr_err && !rd_err && viol_cnt == '0));

  p_write_gap_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_tick && wr_pend && !bus_tick) |=> wr_err);

  p_wr_err_cause_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wr_err) |-> $past(wr_tick));

  p_rd_err_cause_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rd_err) |-> $past(ff_evt));

  p_sticky_wr_r8: assert property (@(posedge clk) disable iff (!rst_n)
    wr_err |=> wr_err);

  p_sticky_rd_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rd_err |=> rd_err);

  p_no_overflow_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (viol_cnt == CMAX) |=> (viol_cnt == CMAX));

  p_cnt_monotone_r9: assert property (@(posedge clk) disable iff (!rst_n)
    viol_cnt >= $past(viol_cnt));

  p_fetch_needs_bus_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ff_evt |-> bus_tick);

endmodule

bind link_order_monitor lom_checker #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_tick(wr_tick), .bus_tick(bus_tick),
  .wr_pend(wr_pend), .ff_evt(ff_evt), .wr_err(wr_err), .rd_err(rd_err),
  .viol_cnt(viol_cnt)
);

// File: tb/link_order_monitor_tb_top.sv
`timescale 1ns/1ps
module link_order_monitor_tb_top;

  localparam int CNT_W = 4;
  localparam int NV    = 42;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_tick = 1'b0, bus_tick = 1'b0, rd_tick = 1'b0;
  logic wr_err, rd_err;
  logic [CNT_W-1:0] viol_cnt;
  int checks = 0, fails = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  link_order_monitor #(.CNT_W(CNT_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .wr_tick(wr_tick), .bus_tick(bus_tick),
    .rd_tick(rd_tick), .wr_err(wr_err), .rd_err(rd_err), .viol_cnt(viol_cnt)
  );

  // {rst, wr, bus, rd, exp_wr_err, exp_rd_err, exp_cnt[3:0]}
  localparam logic [9:0] VEC [NV] = '{
    10'b1_0_0_0_0_0_0000, 10'b0_1_0_0_0_0_0000, 10'b0_0_1_0_0_0_0000,
    10'b0_0_1_0_0_0_0000, 10'b0_0_1_0_0_0_0000, 10'b0_0_0_1_0_0_0000,
    10'b0_1_0_0_0_0_0000, 10'b0_0_1_0_0_0_0000, 10'b0_0_0_1_0_0_0000,
    10'b0_1_1_0_0_0_0000, 10'b0_1_0_0_1_0_0001,
    10'b1_0_0_0_0_0_0000, 10'b0_1_0_0_0_0_0000, 10'b0_1_1_0_0_0_0000,
    10'b0_0_1_1_0_0_0000, 10'b0_1_0_0_0_0_0000, 10'b0_0_1_0_0_1_0001,
    10'b1_0_0_0_0_0_0000, 10'b0_1_0_0_0_0_0000,
    10'b0_1_0_0_1_0_0001, 10'b0_1_0_0_1_0_0010, 10'b0_1_0_0_1_0_0011,
    10'b0_1_0_0_1_0_0100, 10'b0_1_0_0_1_0_0101, 10'b0_1_0_0_1_0_0110,
    10'b0_1_0_0_1_0_0111, 10'b0_1_0_0_1_0_1000, 10'b0_1_0_0_1_0_1001,
    10'b0_1_0_0_1_0_1010, 10'b0_1_0_0_1_0_1011, 10'b0_1_0_0_1_0_1100,
    10'b0_1_0_0_1_0_1101, 10'b0_1_0_0_1_0_1110, 10'b0_1_0_0_1_0_1111,
    10'b0_1_0_0_1_0_1111, 10'b0_0_0_0_1_0_1111,
    10'b1_0_0_0_0_0_0000, 10'b0_1_0_0_0_0_0000, 10'b0_0_1_0_0_0_0000,
    10'b0_1_0_0_0_0_0000, 10'b0_0_1_0_0_1_0001, 10'b0_0_0_0_0_1_0001
  };

  function automatic string req_of(input int i);
    if (i == 0 || i == 11 || i == 17 || i == 36) return "R1";
    if (i <= 9)  return "R10";
    if (i == 10) return "R4";
    if (i == 13) return "R3";
    if (i == 14) return "R6";
    if (i == 16) return "R7";
    if (i <= 18) return "R2";
    if (i <= 34) return "R9";
    if (i == 35 || i == 41) return "R8";
    return "R5";
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: got %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic check_all(input string req, input logic ew, input logic er,
                           input logic [CNT_W-1:0] ec);
    chk(req, int'(wr_err), int'(ew));
    chk(req, int'(rd_err), int'(er));
    chk(req, int'(viol_cnt), int'(ec));
  endtask

  task automatic drive(input logic w, input logic b, input logic r);
    wr_tick = w; bus_tick = b; rd_tick = r;
  endtask

  initial begin
    @(negedge clk);
    for (int i = 0; i < NV; i++) begin
      rst_n = ~VEC[i][9];
      drive(VEC[i][8], VEC[i][7], VEC[i][6]);
      @(negedge clk);
      check_all(req_of(i), VEC[i][5], VEC[i][4], VEC[i][3:0]);
    end
    // R1: asynchronous reset clears the sticky state without a clock edge
    drive(1'b0, 1'b0, 1'b0);
    rst_n = 1'b0;
    #1;
    check_all("R1", 1'b0, 1'b0, '0);
    @(negedge clk);
    rst_n = 1'b1;
    // R10: bus and read ticks alone, no write ever made
    drive(1'b0, 1'b1, 1'b0); @(negedge clk);
    drive(1'b0, 1'b1, 1'b1); @(negedge clk);
    drive(1'b0, 1'b0, 1'b1); @(negedge clk);
    drive(1'b0, 1'b1, 1'b0); @(negedge clk);
    drive(1'b0, 1'b0, 1'b0); @(negedge clk);
    check_all("R10", 1'b0, 1'b0, '0);
    // R7 and R5 again: fetch with read coincident, then a fetch with no read
    drive(1'b1, 1'b0, 1'b0); @(negedge clk);
    drive(1'b0, 1'b1, 1'b1); @(negedge clk);
    drive(1'b1, 1'b0, 1'b1); @(negedge clk);
    drive(1'b0, 1'b1, 1'b0); @(negedge clk);
    check_all("R5", 1'b0, 1'b0, '0);
    drive(1'b1, 1'b0, 1'b0); @(negedge clk);
    drive(1'b0, 1'b1, 1'b0); @(negedge clk);
    check_all("R7", 1'b0, 1'b1, 4'd1);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    #100000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

endmodule